// File: doc/BRIEF.md
# Fixed-Latency Synchronous Bus Read Master

This block turns a single-cycle read request from a processor-side requester into a three-period read cycle on a clocked shared bus. When it accepts a request, it drives the word address onto the bus on a rising clock edge. On the following falling edge it pulls two active-low strobes low: a memory-select strobe and a read strobe. The strobes stay low through the second period. In the third period the block samples the data bus blindly on the falling edge and lets both strobes go high again at that same edge. It never waits for an acknowledge from the slave. The captured word comes back to the requester with a one-cycle completion pulse.

The controller is a four-state machine. `IDLE` waits for a request. `T1` is the address period, `T2` is the access period, and `T3` is the capture-and-release period. The named transitions are: ACCEPT (`IDLE`→`T1`, taken when a request is present), LAUNCH (`T1`→`T2`), ACCESS (`T2`→`T3`) and FINISH (`T3`→`IDLE`). All of them except ACCEPT are unconditional. FINISH raises the completion pulse for the next cycle, and a new request may be accepted in that same cycle. The requester sees `busy` while the machine is in `T1`, `T2` or `T3`.

Top module: `sync_rd_master`

## Requirements
- R1: While reset is asserted and right after it is released, `mem_sel_n` and `rd_strobe_n` are 1, `busy` and `done` are 0, and `bus_addr` and `done_data` are 0.
- R2: When `req_valid` is 1 at a rising edge while `busy` is 0, `bus_addr` takes `req_addr` at that edge and holds it for three clock periods (T1, T2, T3).
- R3: The strobes stay at 1 during the first half of T1. They go to 0 at the falling edge inside T1, never before the address is on the bus.
- R4: Both strobes are active low (0 means asserted) and always move together. They stay at 0 through all of T2 and the first half of T3, and return to 1 at the falling edge inside T3.
- R5: The data bus is sampled only at the falling edge inside T3, with no acknowledge input. Values on the data bus at any other time have no effect on `done_data`.
- R6: `done` is 1 for exactly the one cycle that follows T3, with `done_data` equal to the word sampled in T3. `done_data` then holds until the next completion.
- R7: `busy` is 1 during T1, T2 and T3. A request presented while `busy` is 1 is ignored: it starts no transaction and does not change `bus_addr`.
- R8: A request presented in the cycle where `done` is 1 is accepted at once, so the next T1 follows T3 with exactly one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; strobes and data capture use its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request from the requester |
| req_addr | input | 32 | Word address to read |
| busy | output | 1 | Transaction in progress; requests are ignored |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | 32 | Word returned by the last read |
| bus_addr | output | 32 | Address lines of the shared bus |
| bus_data | input | 32 | Data lines of the shared bus |
| mem_sel_n | output | 1 | Active-low memory-select strobe |
| rd_strobe_n | output | 1 | Active-low read strobe |

## Verification
The bench slave drives a value derived from the address only while both strobes are low, and a fixed garbage word otherwise. A design that samples outside the strobe window therefore returns garbage, and one that drops the strobes one half-period late or early is caught by comparisons taken in both halves of every cycle. A request held high across a whole transaction, with its address changing, exposes a master that re-accepts or re-latches while busy. Back-to-back requests issued in the completion cycle catch a machine that adds or loses an idle cycle after FINISH. Reads of addresses 0 and all-ones exercise the full width of the address and data paths.

// File: rtl/srm_pkg.sv
package srm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_T1   = 2'd1,
        ST_T2   = 2'd2,
        ST_T3   = 2'd3
    } bus_state_e;
endpackage

// File: rtl/srm_fsm.sv
module srm_fsm
    import srm_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] cap_data,
    output bus_state_e        state,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [ADDR_W-1:0] bus_addr
);
    bus_state_e state_q, state_d;

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_T1;  // ACCEPT
            ST_T1:   state_d = ST_T2;                 // LAUNCH
            ST_T2:   state_d = ST_T3;                 // ACCESS
            ST_T3:   state_d = ST_IDLE;               // FINISH
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            done      <= 1'b0;
            done_data <= '0;
        end else begin
            done <= (state_q == ST_T3);
            if (state_q == ST_IDLE && req_valid) bus_addr <= req_addr;
            if (state_q == ST_T3) done_data <= cap_data;
        end
    end

    assign state = state_q;
    assign busy  = (state_q != ST_IDLE);

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_T2 || state_q == ST_T3) |-> $stable(bus_addr));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state_q != ST_T3) |=> $stable(bus_addr));
    assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req_valid) |=> (state_q == ST_T1));
endmodule

// File: rtl/srm_strobe.sv
module srm_strobe
    import srm_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_e        state,
    input  logic [DATA_W-1:0] bus_data,
    output logic [DATA_W-1:0] cap_data,
    output logic              mem_sel_n,
    output logic              rd_strobe_n
);
    logic strobe_on;

    // falling-edge launch of strobes and blind data capture
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_on <= 1'b0;
            cap_data  <= '0;
        end else begin
            strobe_on <= (state == ST_T1) || (state == ST_T2);
            if (state == ST_T3) cap_data <= bus_data;
        end
    end

    assign mem_sel_n   = ~strobe_on;
    assign rd_strobe_n = ~strobe_on;

    assert_strobe_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T1 || state == ST_T2) |-> (!mem_sel_n && !rd_strobe_n));
    assert_strobe_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_T3) |-> (mem_sel_n && rd_strobe_n));
endmodule

// File: rtl/sync_rd_master.sv
module sync_rd_master #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              mem_sel_n,
    output logic              rd_strobe_n
);
    srm_pkg::bus_state_e state;
    logic [DATA_W-1:0]   cap_data;

    srm_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .cap_data(cap_data), .state(state), .busy(busy), .done(done),
        .done_data(done_data), .bus_addr(bus_addr)
    );

    srm_strobe #(.DATA_W(DATA_W)) strobe_i (
        .clk(clk), .rst_n(rst_n), .state(state), .bus_data(bus_data),
        .cap_data(cap_data), .mem_sel_n(mem_sel_n), .rd_strobe_n(rd_strobe_n)
    );
endmodule

// File: tb/sync_rd_master_tb_top.sv
module sync_rd_master_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        busy, done, mem_sel_n, rd_strobe_n;
    logic [31:0] done_data, bus_addr, bus_data;

    int vectors = 0;
    int misses  = 0;

    // reference model state
    int          cnt = 0;
    logic [31:0] eaddr = '0;
    logic [31:0] edata = '0;
    logic        edone = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return {a[15:0], ~a[31:16]} ^ 32'h1234_5678;
    endfunction

    // simple slave: valid word only while both strobes are low
    assign bus_data = (!mem_sel_n && !rd_strobe_n) ? memf(bus_addr) : 32'hDEAD_BEEF;

    sync_rd_master dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .busy(busy), .done(done), .done_data(done_data), .bus_addr(bus_addr),
        .bus_data(bus_data), .mem_sel_n(mem_sel_n), .rd_strobe_n(rd_strobe_n)
    );

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            misses++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic compare(input bit second_half);
        bit low;
        vectors++;
        low = second_half ? (cnt == 1 || cnt == 2) : (cnt == 2 || cnt == 3);
        cmp("R3/R4 mem_sel_n", {31'd0, mem_sel_n}, {31'd0, !low});
        cmp("R4 rd_strobe_n", {31'd0, rd_strobe_n}, {31'd0, !low});
        cmp("R7 busy", {31'd0, busy}, {31'd0, cnt != 0});
        cmp("R2 bus_addr", bus_addr, eaddr);
        cmp("R6 done", {31'd0, done}, {31'd0, edone});
        cmp("R5/R6 done_data", done_data, edata);
    endtask

    // one clock period: inputs already set, model steps at rising edge
    task automatic step(input logic v, input logic [31:0] a);
        req_valid = v;
        req_addr  = a;
        @(posedge clk);
        #5;
        edone = 1'b0;
        case (cnt)
            0: if (v) begin cnt = 1; eaddr = a; end
            1: cnt = 2;
            2: cnt = 3;
            default: begin cnt = 0; edone = 1'b1; edata = memf(eaddr); end
        endcase
        compare(1'b0);
        @(negedge clk);
        #5;
        compare(1'b1);
    endtask

    initial begin
        #1000000;
        misses++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        // R1: reset state
        #15;
        compare(1'b1);
        @(negedge clk);
        #5;
        rst_n = 1'b1;
        compare(1'b1);
        step(1'b0, 32'h0);
        // R2 R3 R4 R5 R6: single read
        step(1'b1, 32'h0000_1234);
        for (int i = 0; i < 5; i++) step(1'b0, 32'h0);
        // R7: request held while busy with changing address
        step(1'b1, 32'hCAFE_0001);
        step(1'b1, 32'hCAFE_0002);
        step(1'b1, 32'hCAFE_0003);
        step(1'b1, 32'hCAFE_0004);
        step(1'b0, 32'h0);
        for (int i = 0; i < 3; i++) step(1'b0, 32'h0);
        // R8: back-to-back through the completion cycle, boundary addresses
        step(1'b1, 32'h0000_0000);
        step(1'b0, 32'h0);
        step(1'b0, 32'h0);
        step(1'b0, 32'h0);
        step(1'b1, 32'hFFFF_FFFF);
        step(1'b0, 32'h0);
        step(1'b0, 32'h0);
        step(1'b0, 32'h0);
        step(1'b1, 32'h8000_0001);
        for (int i = 0; i < 6; i++) step(1'b0, 32'h0);
        // R6: done_data holds across idle cycles
        for (int i = 0; i < 4; i++) step(1'b0, 32'h5555_AAAA);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule